// File: doc/BRIEF.md
# Two-Level Paged Address Translator with Write Protection

This block turns the virtual word address of a processor access into a physical word address. The active context number and the segment field of the address select an entry in a segment table. That entry names a page group. The page group and the page field of the address then select a 32-bit page descriptor. The descriptor supplies the physical page number, a two-bit target space, a valid flag, the write-permission and supervisor-only flags, and the referenced and dirty flags. Translation is combinational, so the physical request appears in the same cycle as the access. Flag updates commit on the clock edge that ends the access.

A write is allowed only when the descriptor grants write permission. It must also not be a user-mode write to a supervisor-only page. The mode is taken from bit 0 of the access's address-space identifier. A refused write is dropped. The block then records a fault code and the faulting byte address in a two-word fault record, and raises a memory-fault interrupt. Reading a fault word returns it, clears it and drops the interrupt.

A small register port gives access to the context register, a control register, the fault record, the segment table and the descriptor table. Writing the control register with its restart bit set clears the register and sends a one-cycle restart pulse to the processor.

Top module: `paged_mmu`

## Requirements
- R1: For a translated access, phys_addr equals descriptor bits [15:0] followed by acc_vaddr[9:0] (4 KiB pages). acc_vaddr is laid out as segment [VA_W-1:14], page [13:10] and offset [9:0].
- R2: phys_space equals descriptor bits [27:26].
- R3: If descriptor bit 31 (valid) is 0, phys_en stays 0, acc_rdata is 0 and the descriptor is not changed, for both reads and writes.
- R4: A write through a valid descriptor whose bit 30 (write permission) is 0 is refused: phys_en stays 0 and the descriptor is not changed.
- R5: A write through a valid descriptor whose bit 29 (supervisor-only) is 1 is refused when acc_asi[0] is 0. It is allowed when acc_asi[0] is 1 and bit 30 is 1.
- R6: A refused write loads fault word 0 with 0x8040 and fault word 1 with the byte address {acc_vaddr,2'b00}. It asserts mae_irq from the next cycle.
- R7: An allowed write sets descriptor bit 25 (referenced) and bit 24 (dirty), and drives phys_en=1, phys_we=1 and phys_wdata=acc_wdata.
- R8: A read through a valid descriptor checks neither permission flag. It returns phys_rdata on acc_rdata and sets bit 25 only.
- R9: A register read of the fault record (reg_sel=2, reg_index[0] picks the word) returns the stored word, clears it to 0 and deasserts mae_irq. A register write loads the word.
- R10: Writing the control register (reg_sel=1) with bit 7 set leaves it 0 and drives cpu_reset high for exactly one cycle. Other writes store reg_wdata[7:0].
- R11: The context register (reg_sel=0) selects which segment-table row is used for translation and for segment-table access (reg_sel=3, index = segment). reg_sel=4 accesses the descriptor at index {group,page}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_asi | input | ASI_W | Address-space identifier, bit 0 = supervisor |
| acc_vaddr | input | VA_W | Virtual word address |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, 0 when not transferred |
| phys_en | output | 1 | Physical transfer enable |
| phys_we | output | 1 | Physical write |
| phys_addr | output | PA_W | Physical word address |
| phys_space | output | 2 | Target space type |
| phys_wdata | output | 32 | Physical write data |
| phys_rdata | input | 32 | Physical read data |
| reg_valid | input | 1 | Register port request |
| reg_write | input | 1 | Register port write |
| reg_sel | input | 3 | 0 context, 1 control, 2 fault, 3 segment table, 4 descriptor table |
| reg_index | input | IDX_W | Word or table index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| mae_irq | output | 1 | Memory-fault interrupt |
| cpu_reset | output | 1 | One-cycle processor restart pulse |

## Verification
The translator is driven with reads and writes through descriptors that differ in one flag at a time. The cases are writable, write-protected, supervisor-only and invalid. Each is tried with user and supervisor identifiers, so that a wrong permission term shows up as a transfer that should not happen or a fault that should not be raised. The descriptors are read back after every access. This separates the referenced-only update of reads from the referenced-and-dirty update of writes, and shows that denied or invalid accesses leave the descriptor untouched. The context is switched between two rows that map the same segment to different page groups, and the fault record is read twice, to tell clear-on-read from a plain register.

// File: rtl/paged_mmu.sv
module paged_mmu #(
  parameter int CTX_BITS  = 3,
  parameter int SEG_BITS  = 5,
  parameter int PAGE_BITS = 4,
  parameter int PMEG_BITS = 5,
  parameter int ASI_W     = 8,
  localparam int OFF_BITS = 10,
  localparam int VA_W     = SEG_BITS + PAGE_BITS + OFF_BITS,
  localparam int PA_W     = 16 + OFF_BITS,
  localparam int PM_AW    = PMEG_BITS + PAGE_BITS,
  localparam int SM_AW    = CTX_BITS + SEG_BITS,
  localparam int IDX_W    = (PM_AW > SEG_BITS) ? PM_AW : SEG_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [ASI_W-1:0] acc_asi,
  input  logic [VA_W-1:0]  acc_vaddr,
  input  logic [31:0]      acc_wdata,
  output logic [31:0]      acc_rdata,
  output logic             phys_en,
  output logic             phys_we,
  output logic [PA_W-1:0]  phys_addr,
  output logic [1:0]       phys_space,
  output logic [31:0]      phys_wdata,
  input  logic [31:0]      phys_rdata,
  input  logic             reg_valid,
  input  logic             reg_write,
  input  logic [2:0]       reg_sel,
  input  logic [IDX_W-1:0] reg_index,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             mae_irq,
  output logic             cpu_reset
);

  localparam int B_VALID = 31;
  localparam int B_WREN  = 30;
  localparam int B_SUPER = 29;
  localparam int B_REF   = 25;
  localparam int B_DIRTY = 24;
  localparam int B_RST   = 7;
  localparam logic [31:0] FAULT_CODE = 32'h0000_8040;

  logic [PMEG_BITS-1:0] segmap [2**SM_AW];
  logic [31:0]          pagemap [2**PM_AW];
  logic [CTX_BITS-1:0]  ctx_q;
  logic [7:0]           sysen_q;
  logic [31:0]          berr0_q, berr1_q;
  logic                 mae_q, rst_pulse_q;

  logic [SEG_BITS-1:0]  seg;
  logic [PAGE_BITS-1:0] page;
  logic [PMEG_BITS-1:0] pmeg;
  logic [PM_AW-1:0]     pm_idx;
  logic [31:0]          pte;
  logic                 wr_ok, hit, fault;
  logic                 sel_ctx, sel_sys, sel_berr, sel_seg, sel_pm;
  logic                 berr_rd, berr_wr;
  logic [31:0]          byte_addr;
  logic                 unused_asi;

  assign unused_asi = ^acc_asi[ASI_W-1:1];

  assign seg    = acc_vaddr[VA_W-1 -: SEG_BITS];
  assign page   = acc_vaddr[OFF_BITS +: PAGE_BITS];
  assign pmeg   = segmap[{ctx_q, seg}];
  assign pm_idx = {pmeg, page};
  assign pte    = pagemap[pm_idx];

  assign wr_ok = pte[B_WREN] & (~pte[B_SUPER] | acc_asi[0]);
  assign hit   = acc_valid & pte[B_VALID] & (~acc_write | wr_ok);
  assign fault = acc_valid & acc_write & pte[B_VALID] & ~wr_ok;

  assign phys_en    = hit;
  assign phys_we    = hit & acc_write;
  assign phys_addr  = {pte[15:0], acc_vaddr[OFF_BITS-1:0]};
  assign phys_space = pte[27:26];
  assign phys_wdata = acc_wdata;
  assign acc_rdata  = (hit & ~acc_write) ? phys_rdata : 32'h0;
  assign byte_addr  = 32'({acc_vaddr, 2'b00});

  assign sel_ctx  = reg_valid & (reg_sel == 3'd0);
  assign sel_sys  = reg_valid & (reg_sel == 3'd1);
  assign sel_berr = reg_valid & (reg_sel == 3'd2);
  assign sel_seg  = reg_valid & (reg_sel == 3'd3);
  assign sel_pm   = reg_valid & (reg_sel == 3'd4);
  assign berr_rd  = sel_berr & ~reg_write;
  assign berr_wr  = sel_berr & reg_write;

  always_comb begin
    unique case (reg_sel)
      3'd0:    reg_rdata = 32'(ctx_q);
      3'd1:    reg_rdata = 32'(sysen_q);
      3'd2:    reg_rdata = reg_index[0] ? berr1_q : berr0_q;
      3'd3:    reg_rdata = 32'(segmap[{ctx_q, reg_index[SEG_BITS-1:0]}]);
      3'd4:    reg_rdata = pagemap[reg_index[PM_AW-1:0]];
      default: reg_rdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (sel_seg && reg_write)
      segmap[{ctx_q, reg_index[SEG_BITS-1:0]}] <= reg_wdata[PMEG_BITS-1:0];
  end

  always_ff @(posedge clk) begin
    if (sel_pm && reg_write)
      pagemap[reg_index[PM_AW-1:0]] <= reg_wdata;
    else if (hit)
      pagemap[pm_idx] <= pte | (32'h1 << B_REF) | (acc_write ? (32'h1 << B_DIRTY) : 32'h0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_q       <= '0;
      sysen_q     <= '0;
      rst_pulse_q <= 1'b0;
    end else begin
      rst_pulse_q <= 1'b0;
      if (sel_ctx && reg_write) ctx_q <= reg_wdata[CTX_BITS-1:0];
      if (sel_sys && reg_write) begin
        if (reg_wdata[B_RST]) begin
          sysen_q     <= '0;
          rst_pulse_q <= 1'b1;
        end else begin
          sysen_q <= reg_wdata[7:0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      berr0_q <= '0;
      berr1_q <= '0;
      mae_q   <= 1'b0;
    end else if (fault) begin
      berr0_q <= FAULT_CODE;
      berr1_q <= byte_addr;
      mae_q   <= 1'b1;
    end else begin
      if (berr_wr && !reg_index[0]) berr0_q <= reg_wdata;
      if (berr_wr &&  reg_index[0]) berr1_q <= reg_wdata;
      if (berr_rd && !reg_index[0]) berr0_q <= '0;
      if (berr_rd &&  reg_index[0]) berr1_q <= '0;
      if (berr_rd) mae_q <= 1'b0;
    end
  end

  assign mae_irq   = mae_q;
  assign cpu_reset = rst_pulse_q;

endmodule

// File: rtl/paged_mmu_props.sv
module paged_mmu_props (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic        acc_write,
  input logic        asi_super,
  input logic [31:0] pte,
  input logic [31:0] acc_rdata,
  input logic        phys_en,
  input logic        mae_irq,
  input logic        cpu_reset,
  input logic        berr_rd,
  input logic        fault
);

  a_r3_invalid_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !pte[31]) |-> (!phys_en && acc_rdata == 32'h0));

  a_r4_wren_clear_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && pte[31] && !pte[30]) |-> !phys_en ##1 mae_irq);

  a_r5_user_super_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && pte[31] && pte[29] && !asi_super) |-> !phys_en ##1 mae_irq);

  a_r8_read_unchecked: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && pte[31]) |-> phys_en);

  a_r9_read_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (berr_rd && !fault) |=> !mae_irq);

  a_r10_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_reset |=> !cpu_reset);

endmodule

bind paged_mmu paged_mmu_props u_props (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .acc_write (acc_write),
  .asi_super (acc_asi[0]),
  .pte       (pte),
  .acc_rdata (acc_rdata),
  .phys_en   (phys_en),
  .mae_irq   (mae_irq),
  .cpu_reset (cpu_reset),
  .berr_rd   (berr_rd),
  .fault     (fault)
);

// File: tb/paged_mmu_tb_top.sv
module paged_mmu_tb_top;
  localparam int VA_W = 19;
  localparam int PA_W = 26;
  localparam int IDX_W = 9;

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_write = 0;
  logic [7:0] acc_asi = 0;
  logic [VA_W-1:0] acc_vaddr = 0;
  logic [31:0] acc_wdata = 0, acc_rdata, phys_wdata, phys_rdata = 0;
  logic phys_en, phys_we, mae_irq, cpu_reset;
  logic [PA_W-1:0] phys_addr;
  logic [1:0] phys_space;
  logic reg_valid = 0, reg_write = 0;
  logic [2:0] reg_sel = 0;
  logic [IDX_W-1:0] reg_index = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;

  int total = 0, bad = 0;
  bit done = 0;

  paged_mmu dut_i (.*);

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [VA_W-1:0] va(input int s, input int p, input int o);
    return VA_W'((s << 14) | (p << 10) | o);
  endfunction

  function automatic logic [IDX_W-1:0] pmi(input int g, input int p);
    return IDX_W'((g << 4) | p);
  endfunction

  task automatic rg(input logic [2:0] sel, input logic [IDX_W-1:0] idx, input logic wr,
                    input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    reg_valid = 1; reg_write = wr; reg_sel = sel; reg_index = idx; reg_wdata = wd;
    #1 rd = reg_rdata;
    @(posedge clk); #1;
    reg_valid = 0; reg_write = 0;
  endtask

  task automatic wr_reg(input logic [2:0] sel, input logic [IDX_W-1:0] idx, input logic [31:0] wd);
    logic [31:0] d;
    rg(sel, idx, 1'b1, wd, d);
  endtask

  task automatic rd_reg(input logic [2:0] sel, input logic [IDX_W-1:0] idx, output logic [31:0] rd);
    rg(sel, idx, 1'b0, 32'h0, rd);
  endtask

  logic s_en, s_we;
  logic [PA_W-1:0] s_addr;
  logic [1:0] s_space;
  logic [31:0] s_rdata, s_wdata;

  task automatic acc(input logic wr, input logic sup, input logic [VA_W-1:0] a, input logic [31:0] wd);
    @(negedge clk);
    acc_valid = 1; acc_write = wr; acc_asi = {7'h0, sup}; acc_vaddr = a; acc_wdata = wd;
    #1;
    s_en = phys_en; s_we = phys_we; s_addr = phys_addr; s_space = phys_space;
    s_rdata = acc_rdata; s_wdata = phys_wdata;
    @(posedge clk); #1;
    acc_valid = 0; acc_write = 0;
  endtask

  task automatic setup_maps;
    wr_reg(3'd0, 0, 32'd0);
    wr_reg(3'd3, 1, 32'd3);
    wr_reg(3'd4, pmi(3,0), 32'hC800_1234);
    wr_reg(3'd4, pmi(3,1), 32'h8400_0055);
    wr_reg(3'd4, pmi(3,2), 32'hE000_0077);
    wr_reg(3'd4, pmi(3,3), 32'h4000_0099);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    #1;
    chk("R10 reset cpu_reset", 32'(cpu_reset), 0);
    chk("R6 reset mae_irq", 32'(mae_irq), 0);
    chk("R3 idle phys_en", 32'(phys_en), 0);
    rd_reg(3'd1, 0, d); chk("R10 reset control", d, 0);
    rd_reg(3'd2, 0, d); chk("R9 reset fault0", d, 0);
  endtask

  task automatic t_translate;
    logic [31:0] d;
    phys_rdata = 32'hDEAD_BEEF;
    acc(1'b0, 1'b0, va(1,0,'h2AB), 0);
    chk("R1 phys_addr", 32'(s_addr), 32'({16'h1234, 10'h2AB}));
    chk("R2 phys_space", 32'(s_space), 2);
    chk("R8 read data", s_rdata, 32'hDEAD_BEEF);
    chk("R8 read not write", 32'(s_we), 0);
    rd_reg(3'd4, pmi(3,0), d); chk("R8 read sets referenced only", d, 32'hCA00_1234);
  endtask

  task automatic t_write_ok;
    logic [31:0] d;
    acc(1'b1, 1'b0, va(1,0,5), 32'h0BAD_F00D);
    chk("R7 phys_en", 32'(s_en), 1);
    chk("R7 phys_we", 32'(s_we), 1);
    chk("R7 phys_wdata", s_wdata, 32'h0BAD_F00D);
    chk("R7 no irq", 32'(mae_irq), 0);
    rd_reg(3'd4, pmi(3,0), d); chk("R7 ref+dirty set", d, 32'hCB00_1234);
  endtask

  task automatic t_wren_deny;
    logic [31:0] d;
    acc(1'b1, 1'b1, va(1,1,'h3C), 32'h1111_2222);
    chk("R4 no transfer", 32'(s_en), 0);
    chk("R6 irq raised", 32'(mae_irq), 1);
    rd_reg(3'd4, pmi(3,1), d); chk("R4 descriptor unchanged", d, 32'h8400_0055);
    rd_reg(3'd2, 1, d); chk("R6 fault address", d, 32'({va(1,1,'h3C), 2'b00}));
    chk("R9 irq cleared by read", 32'(mae_irq), 0);
    rd_reg(3'd2, 0, d); chk("R6 fault code", d, 32'h8040);
    rd_reg(3'd2, 0, d); chk("R9 word cleared", d, 0);
  endtask

  task automatic t_super;
    logic [31:0] d;
    acc(1'b1, 1'b0, va(1,2,0), 32'h5);
    chk("R5 user write refused", 32'(s_en), 0);
    chk("R5 user write irq", 32'(mae_irq), 1);
    rd_reg(3'd2, 0, d);
    rd_reg(3'd4, pmi(3,2), d); chk("R5 descriptor unchanged", d, 32'hE000_0077);
    acc(1'b1, 1'b1, va(1,2,0), 32'h5);
    chk("R5 supervisor write allowed", 32'(s_en), 1);
    chk("R5 no irq", 32'(mae_irq), 0);
    rd_reg(3'd4, pmi(3,2), d); chk("R7 supervisor write flags", d, 32'hE300_0077);
  endtask

  task automatic t_read_nocheck;
    logic [31:0] d;
    phys_rdata = 32'h0000_CAFE;
    acc(1'b0, 1'b0, va(1,1,7), 0);
    chk("R8 read of protected page", 32'(s_en), 1);
    chk("R8 read data", s_rdata, 32'h0000_CAFE);
    chk("R2 space type 1", 32'(s_space), 1);
    rd_reg(3'd4, pmi(3,1), d); chk("R8 referenced only", d, 32'h8600_0055);
  endtask

  task automatic t_invalid;
    logic [31:0] d;
    phys_rdata = 32'h7777_7777;
    acc(1'b0, 1'b1, va(1,3,0), 0);
    chk("R3 read no transfer", 32'(s_en), 0);
    chk("R3 read returns zero", s_rdata, 0);
    acc(1'b1, 1'b1, va(1,3,0), 32'h9);
    chk("R3 write no transfer", 32'(s_en), 0);
    chk("R3 write no irq", 32'(mae_irq), 0);
    rd_reg(3'd4, pmi(3,3), d); chk("R3 descriptor unchanged", d, 32'h4000_0099);
  endtask

  task automatic t_berr_write;
    logic [31:0] d;
    wr_reg(3'd2, 1, 32'h0000_1357);
    rd_reg(3'd2, 1, d); chk("R9 loaded word", d, 32'h1357);
    rd_reg(3'd2, 1, d); chk("R9 cleared after read", d, 0);
  endtask

  task automatic t_context;
    logic [31:0] d;
    wr_reg(3'd0, 0, 32'd1);
    rd_reg(3'd0, 0, d); chk("R11 context readback", d, 1);
    wr_reg(3'd3, 1, 32'd4);
    wr_reg(3'd4, pmi(4,0), 32'h8000_0ABC);
    acc(1'b0, 1'b1, va(1,0,1), 0);
    chk("R11 context 1 mapping", 32'(s_addr), 32'({16'h0ABC, 10'h1}));
    wr_reg(3'd0, 0, 32'd0);
    rd_reg(3'd3, 1, d); chk("R11 row 0 segment entry", d, 3);
    acc(1'b0, 1'b1, va(1,0,1), 0);
    chk("R11 context 0 mapping", 32'(s_addr), 32'({16'h1234, 10'h1}));
  endtask

  task automatic t_sysen;
    logic [31:0] d;
    wr_reg(3'd1, 0, 32'h05);
    chk("R10 no pulse on plain write", 32'(cpu_reset), 0);
    rd_reg(3'd1, 0, d); chk("R10 stored", d, 32'h05);
    @(negedge clk);
    reg_valid = 1; reg_write = 1; reg_sel = 3'd1; reg_wdata = 32'h81;
    @(posedge clk); #1;
    reg_valid = 0; reg_write = 0;
    chk("R10 pulse high", 32'(cpu_reset), 1);
    @(posedge clk); #1;
    chk("R10 pulse one cycle", 32'(cpu_reset), 0);
    rd_reg(3'd1, 0, d); chk("R10 register cleared", d, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset;
    setup_maps;
    t_translate;
    t_write_ok;
    t_wren_deny;
    t_super;
    t_read_nocheck;
    t_invalid;
    t_berr_write;
    t_context;
    t_sysen;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule